// File: doc/BRIEF.md
# Quadrature Carrier NCO Mixer

This block moves a selected channel of a sampled 10-bit input, real or complex, down to zero frequency. A 32-bit phase accumulator advances once for each accepted input sample. Its step is the sum of two words. One is a center-frequency word, written through a small register port into a holding register and then moved into the active register by a load strobe. The other is an offset-frequency word that arrives one bit per clock on a serial pin and is framed by a sync strobe. The top bits of the accumulated phase, plus a signed phase offset, address a computed sine/cosine table. The resulting quadrature local oscillator multiplies the input as a complex number, and the two products are rounded to a fixed output width.

Input samples are accepted only on clocks where the active-low sample enable is low, so that enable sets the processing rate. A control register selects offset-binary or two's-complement input coding, and real or complex input. Gain control and filtering belong to the blocks downstream.

Top module: `carrier_mixer`

## Requirements
- R1: While reset is active, and on the first clocks after it is released, `i_out` and `q_out` are 0 and `out_vld` is 0.
- R2: A sample is accepted on every rising edge where `smp_en_n` is low. Its mixed result appears on `i_out`/`q_out` with `out_vld` high after the second rising edge counted from that edge. On edges where `smp_en_n` is high the phase does not advance, and one edge later `out_vld` is low and `i_out`/`q_out` hold their values.
- R3: The 32-bit phase accumulator is 0 after reset. Each accepted sample uses the current phase and then adds the active center word plus the active offset word, modulo 2^32. The table address is phase bits [31:24] (truncated), plus the phase offset, modulo 256.
- R4: `ofs_bit` is shifted in on every clock, most significant bit first. When `ofs_sync` is high on an edge, the last 32 bits received, including the bit on that same edge, become the active offset word. Bits shifted without `ofs_sync` never change the active offset word.
- R5: A write with `wr_addr`=0 sets the center holding register only. The active center word takes the held value on an edge where `cf_load` is high and keeps its value otherwise.
- R6: A write with `wr_addr`=2 sets an 8-bit two's-complement phase offset from `wr_data[7:0]`. Each unit adds pi/128 of phase, which is one table step.
- R7: The table entry for address k (0..255) is sign × round(2047·16p(128−p) / (5·128² − 4p(128−p))), where p = k mod 128 and the sign is negative for k ≥ 128. Sine uses address a and cosine uses address (a+64) mod 256.
- R8: With converted inputs I, Q, `i_out` = sat(floor((I·C + Q·S + 512) / 1024)) and `q_out` = sat(floor((Q·C − I·S + 512) / 1024)), where sat limits the result to the range −2048..2047.
- R9: A write with `wr_addr`=1 sets control bit 0, which selects offset-binary inputs. In that mode each input has its most significant bit inverted before use. When the bit is 0 the inputs are two's complement.
- R10: Control bit 1 selects real input. In that mode `q_in` has no effect, and Q is taken as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| i_in | input | 10 | In-phase input sample |
| q_in | input | 10 | Quadrature input sample |
| smp_en_n | input | 1 | Active-low sample enable |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select: 0 center holding, 1 control, 2 phase offset |
| wr_data | input | 32 | Register write data |
| cf_load | input | 1 | Moves the held center word into the active register |
| ofs_bit | input | 1 | Serial offset-frequency data, most significant bit first |
| ofs_sync | input | 1 | Marks the final bit of an offset word |
| i_out | output | 12 | Mixed in-phase result |
| q_out | output | 12 | Mixed quadrature result |
| out_vld | output | 1 | High for one clock per accepted sample |

## Verification
A sample's mixed result is due two rising edges after the edge that accepts it. The bench drives on falling edges and reads the result on the second falling edge after it lowers the enable. A register write, a center load or a framing strobe takes effect on the edge that samples it, so only samples accepted on later edges use the new value. Every stimulus task therefore completes its write before the next sample is offered. The expected phase is kept in a running model that steps only when a sample is accepted, and an idle stretch with the enable held high checks that the outputs and the phase both stay put.

// File: rtl/cmix_pkg.sv
package cmix_pkg;

  localparam int unsigned REG_AW = 2;

  typedef enum logic [REG_AW-1:0] {
    REG_CF_HOLD = 2'd0,
    REG_CTRL    = 2'd1,
    REG_PHOFF   = 2'd2
  } cmix_reg_e;

  typedef struct packed {
    logic real_in;     // bit 1
    logic offset_bin;  // bit 0
  } cmix_ctrl_t;

  // Rational sine approximation for one table point of a full cycle
  function automatic int sine_point(input int k, input int addr_w, input int amp);
    longint h, p, num, den, mag;
    h   = longint'(1) << (addr_w - 1);
    p   = longint'(k) % h;
    num = 16 * p * (h - p) * longint'(amp);
    den = 5 * h * h - 4 * p * (h - p);
    mag = (num + den / 2) / den;
    if (longint'(k) >= h) mag = -mag;
    return int'(mag);
  endfunction

endpackage

// File: rtl/cmix_regs.sv
module cmix_regs
  import cmix_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned POFF_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [REG_AW-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              cf_load,
  output logic [DATA_W-1:0] cf_active,
  output cmix_ctrl_t        ctrl,
  output logic [POFF_W-1:0] phoff
);

  localparam int unsigned CTRL_W = $bits(cmix_ctrl_t);

  logic [DATA_W-1:0] hold_q, hold_d;
  logic [DATA_W-1:0] cf_q, cf_d;
  cmix_ctrl_t        ctrl_q, ctrl_d;
  logic [POFF_W-1:0] poff_q, poff_d;

  always_comb begin
    hold_d = hold_q;
    ctrl_d = ctrl_q;
    poff_d = poff_q;
    cf_d   = cf_load ? hold_q : cf_q;
    if (wr_en) begin
      case (cmix_reg_e'(wr_addr))
        REG_CF_HOLD: hold_d = wr_data;
        REG_CTRL:    ctrl_d = cmix_ctrl_t'(wr_data[CTRL_W-1:0]);
        REG_PHOFF:   poff_d = wr_data[POFF_W-1:0];
        default:     ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
      cf_q   <= '0;
      ctrl_q <= '0;
      poff_q <= '0;
    end else begin
      hold_q <= hold_d;
      cf_q   <= cf_d;
      ctrl_q <= ctrl_d;
      poff_q <= poff_d;
    end
  end

  assign cf_active = cf_q;
  assign ctrl      = ctrl_q;
  assign phoff     = poff_q;

  // R5
  cf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !cf_load |=> $stable(cf_active));

  // R5
  cf_write_isolated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_addr == 2'd0 && !cf_load) |=> $stable(cf_active));

endmodule

// File: rtl/cmix_nco.sv
module cmix_nco #(
  parameter int unsigned PHASE_W = 32,
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned POFF_W  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               smp_en,
  input  logic               ofs_bit,
  input  logic               ofs_sync,
  input  logic [PHASE_W-1:0] cf_word,
  input  logic [POFF_W-1:0]  phoff,
  output logic [ADDR_W-1:0]  lut_addr
);

  logic [PHASE_W-2:0] sh_q, sh_d;
  logic [PHASE_W-1:0] sh_full;
  logic [PHASE_W-1:0] ofs_q, ofs_d;
  logic [PHASE_W-1:0] acc_q, acc_d;
  logic [ADDR_W-1:0]  addr_q, addr_d;
  logic [ADDR_W-1:0]  poff_ext;

  // Align the phase offset to the table address scale
  if (ADDR_W == POFF_W) begin : g_poff_eq
    assign poff_ext = phoff;
  end else if (ADDR_W > POFF_W) begin : g_poff_pad
    assign poff_ext = {phoff, {(ADDR_W - POFF_W){1'b0}}};
  end else begin : g_poff_cut
    assign poff_ext = phoff[POFF_W-1 -: ADDR_W];
  end

  always_comb begin
    sh_full = {sh_q, ofs_bit};
    sh_d    = sh_full[PHASE_W-2:0];
    ofs_d   = ofs_sync ? sh_full : ofs_q;
    acc_d   = acc_q;
    addr_d  = addr_q;
    if (smp_en) begin
      acc_d  = acc_q + cf_word + ofs_q;
      addr_d = acc_q[PHASE_W-1 -: ADDR_W] + poff_ext;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '0;
      ofs_q  <= '0;
      acc_q  <= '0;
      addr_q <= '0;
    end else begin
      sh_q   <= sh_d;
      ofs_q  <= ofs_d;
      acc_q  <= acc_d;
      addr_q <= addr_d;
    end
  end

  assign lut_addr = addr_q;

  // R4
  ofs_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ofs_sync |=> $stable(ofs_q));

  // R2
  acc_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !smp_en |=> ($stable(acc_q) && $stable(lut_addr)));

endmodule

// File: rtl/cmix_sincos_rom.sv
module cmix_sincos_rom #(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned AMP_W  = 12
) (
  input  logic [ADDR_W-1:0]       addr,
  output logic signed [AMP_W-1:0] sin_o,
  output logic signed [AMP_W-1:0] cos_o
);

  localparam int unsigned N   = 1 << ADDR_W;
  localparam int          AMP = (1 << (AMP_W - 1)) - 1;
  localparam logic [ADDR_W-1:0] QTR = ADDR_W'(N / 4);

  logic signed [AMP_W-1:0] tbl [N];
  logic [ADDR_W-1:0]       cos_addr;

  for (genvar g = 0; g < N; g++) begin : g_tbl
    localparam int V = cmix_pkg::sine_point(g, ADDR_W, AMP);
    assign tbl[g] = AMP_W'(V);
  end

  assign cos_addr = addr + QTR;
  assign sin_o    = tbl[addr];
  assign cos_o    = tbl[cos_addr];

endmodule

// File: rtl/cmix_cmult.sv
module cmix_cmult
  import cmix_pkg::*;
#(
  parameter int unsigned DIN_W = 10,
  parameter int unsigned AMP_W = 12,
  parameter int unsigned OUT_W = 12
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    smp_en,
  input  logic [DIN_W-1:0]        i_raw,
  input  logic [DIN_W-1:0]        q_raw,
  input  cmix_ctrl_t              ctrl,
  input  logic signed [AMP_W-1:0] sin_i,
  input  logic signed [AMP_W-1:0] cos_i,
  output logic signed [OUT_W-1:0] i_out,
  output logic signed [OUT_W-1:0] q_out,
  output logic                    out_vld
);

  localparam int unsigned PROD_W = DIN_W + AMP_W;
  localparam int unsigned SUM_W  = PROD_W + 2;
  localparam int unsigned SHIFT  = PROD_W - OUT_W;
  localparam logic signed [SUM_W-1:0] HALF   = SUM_W'(1) <<< (SHIFT - 1);
  localparam logic signed [SUM_W-1:0] SAT_HI = SUM_W'((2 ** (OUT_W - 1)) - 1);
  localparam logic signed [SUM_W-1:0] SAT_LO = -SAT_HI - SUM_W'(1);

  logic signed [DIN_W-1:0] i_cv, q_cv;
  logic signed [DIN_W-1:0] i_s1_q, q_s1_q, i_s1_d, q_s1_d;
  logic                    v1_q;
  logic signed [SUM_W-1:0] i_w, q_w, c_w, s_w;
  logic signed [SUM_W-1:0] i_sum, q_sum, i_shf, q_shf;
  logic signed [OUT_W-1:0] i_out_q, q_out_q, i_out_d, q_out_d;
  logic                    vld_q;

  // Stage 1: input coding and real/complex selection
  always_comb begin
    i_cv = ctrl.offset_bin ? {~i_raw[DIN_W-1], i_raw[DIN_W-2:0]} : i_raw;
    q_cv = ctrl.offset_bin ? {~q_raw[DIN_W-1], q_raw[DIN_W-2:0]} : q_raw;
    if (ctrl.real_in) q_cv = '0;
    i_s1_d = smp_en ? i_cv : i_s1_q;
    q_s1_d = smp_en ? q_cv : q_s1_q;
  end

  // Stage 2: complex multiply by conj(LO), round, saturate
  always_comb begin
    i_w   = SUM_W'(i_s1_q);
    q_w   = SUM_W'(q_s1_q);
    c_w   = SUM_W'(cos_i);
    s_w   = SUM_W'(sin_i);
    i_sum = i_w * c_w + q_w * s_w;
    q_sum = q_w * c_w - i_w * s_w;
    i_shf = (i_sum + HALF) >>> SHIFT;
    q_shf = (q_sum + HALF) >>> SHIFT;
    i_out_d = i_out_q;
    q_out_d = q_out_q;
    if (v1_q) begin
      if (i_shf > SAT_HI)      i_out_d = SAT_HI[OUT_W-1:0];
      else if (i_shf < SAT_LO) i_out_d = SAT_LO[OUT_W-1:0];
      else                     i_out_d = i_shf[OUT_W-1:0];
      if (q_shf > SAT_HI)      q_out_d = SAT_HI[OUT_W-1:0];
      else if (q_shf < SAT_LO) q_out_d = SAT_LO[OUT_W-1:0];
      else                     q_out_d = q_shf[OUT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      i_s1_q  <= '0;
      q_s1_q  <= '0;
      v1_q    <= 1'b0;
      i_out_q <= '0;
      q_out_q <= '0;
      vld_q   <= 1'b0;
    end else begin
      i_s1_q  <= i_s1_d;
      q_s1_q  <= q_s1_d;
      v1_q    <= smp_en;
      i_out_q <= i_out_d;
      q_out_q <= q_out_d;
      vld_q   <= v1_q;
    end
  end

  assign i_out   = i_out_q;
  assign q_out   = q_out_q;
  assign out_vld = vld_q;

  // R10
  real_q_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_en && ctrl.real_in) |=> (q_s1_q == '0));

  // R2
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !v1_q |=> ($stable(i_out) && $stable(q_out)));

endmodule

// File: rtl/carrier_mixer.sv
module carrier_mixer #(
  parameter int unsigned DIN_W   = 10,
  parameter int unsigned PHASE_W = 32,
  parameter int unsigned ADDR_W  = 8,
  parameter int unsigned POFF_W  = 8,
  parameter int unsigned AMP_W   = 12,
  parameter int unsigned OUT_W   = 12
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [DIN_W-1:0]   i_in,
  input  logic [DIN_W-1:0]   q_in,
  input  logic               smp_en_n,
  input  logic               wr_en,
  input  logic [1:0]         wr_addr,
  input  logic [PHASE_W-1:0] wr_data,
  input  logic               cf_load,
  input  logic               ofs_bit,
  input  logic               ofs_sync,
  output logic [OUT_W-1:0]   i_out,
  output logic [OUT_W-1:0]   q_out,
  output logic               out_vld
);

  import cmix_pkg::*;

  logic [1:0]              rst_sync_q;
  logic                    rst_int_n;
  logic                    smp_en;
  logic [PHASE_W-1:0]      cf_word;
  cmix_ctrl_t              ctrl;
  logic [POFF_W-1:0]       phoff;
  logic [ADDR_W-1:0]       lut_addr;
  logic signed [AMP_W-1:0] lo_sin, lo_cos;
  logic signed [OUT_W-1:0] i_mix, q_mix;

  // Reset asserts at once and leaves on a clock edge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];
  assign smp_en    = ~smp_en_n;

  cmix_regs #(.DATA_W(PHASE_W), .POFF_W(POFF_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .cf_load   (cf_load),
    .cf_active (cf_word),
    .ctrl      (ctrl),
    .phoff     (phoff)
  );

  cmix_nco #(.PHASE_W(PHASE_W), .ADDR_W(ADDR_W), .POFF_W(POFF_W)) u_nco (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .smp_en   (smp_en),
    .ofs_bit  (ofs_bit),
    .ofs_sync (ofs_sync),
    .cf_word  (cf_word),
    .phoff    (phoff),
    .lut_addr (lut_addr)
  );

  cmix_sincos_rom #(.ADDR_W(ADDR_W), .AMP_W(AMP_W)) u_rom (
    .addr  (lut_addr),
    .sin_o (lo_sin),
    .cos_o (lo_cos)
  );

  cmix_cmult #(.DIN_W(DIN_W), .AMP_W(AMP_W), .OUT_W(OUT_W)) u_cmult (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .smp_en  (smp_en),
    .i_raw   (i_in),
    .q_raw   (q_in),
    .ctrl    (ctrl),
    .sin_i   (lo_sin),
    .cos_i   (lo_cos),
    .i_out   (i_mix),
    .q_out   (q_mix),
    .out_vld (out_vld)
  );

  assign i_out = i_mix;
  assign q_out = q_mix;

  // R2
  sample_to_valid_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    !smp_en_n |-> ##2 out_vld);

  // R2
  idle_no_valid_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    smp_en_n |-> ##2 !out_vld);

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_int_n |-> (out_vld == 1'b0 && i_out == '0 && q_out == '0));

endmodule

// File: tb/test_carrier_mixer.sv
module test_carrier_mixer;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [9:0]  i_in, q_in;
  logic        smp_en_n;
  logic        wr_en;
  logic [1:0]  wr_addr;
  logic [31:0] wr_data;
  logic        cf_load, ofs_bit, ofs_sync;
  logic [11:0] i_out, q_out;
  logic        out_vld;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // Bench-side model state, derived from the requirements
  logic [31:0] m_acc, m_cf, m_hold, m_ofs;
  logic [7:0]  m_poff;
  logic [1:0]  m_ctrl;

  always #5 clk = ~clk;

  carrier_mixer i_carrier_mixer (
    .clk(clk), .rst_n(rst_n), .i_in(i_in), .q_in(q_in), .smp_en_n(smp_en_n),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data), .cf_load(cf_load),
    .ofs_bit(ofs_bit), .ofs_sync(ofs_sync), .i_out(i_out), .q_out(q_out),
    .out_vld(out_vld)
  );

  localparam int NV = 8;
  localparam logic [9:0]  V_I    [NV] = '{10'd300, 10'h338, 10'd511, 10'h3FF,
                                          10'd250, 10'h100, 10'h200, 10'd123};
  localparam logic [9:0]  V_Q    [NV] = '{10'd0, 10'd150, 10'h200, 10'h000,
                                          10'd400, 10'h3FF, 10'h200, 10'h3B3};
  localparam logic [1:0]  V_CTRL [NV] = '{2'd0, 2'd0, 2'd0, 2'd1, 2'd2, 2'd3, 2'd0, 2'd0};
  localparam logic [7:0]  V_POFF [NV] = '{8'd0, 8'd64, 8'h80, 8'd5, 8'd0, 8'hC0, 8'd32, 8'hFF};
  localparam logic [31:0] V_CF   [NV] = '{32'h0000_0000, 32'h0100_0000, 32'h0400_0000,
                                          32'hF800_0000, 32'h1234_5678, 32'h8000_0000,
                                          32'h2000_0000, 32'h0000_0001};

  function automatic int lut(input int k);
    longint p, num, den, mag;
    p   = k % 128;
    num = 16 * p * (128 - p) * 2047;
    den = 5 * 128 * 128 - 4 * p * (128 - p);
    mag = (num + den / 2) / den;
    return (k >= 128) ? -int'(mag) : int'(mag);
  endfunction

  function automatic int conv(input logic [9:0] raw, input logic ob);
    logic [9:0] c;
    c = ob ? {~raw[9], raw[8:0]} : raw;
    return int'($signed(c));
  endfunction

  function automatic int rnd_sat(input longint full);
    longint r;
    r = (full + 512) >>> 10;
    if (r > 2047) r = 2047;
    if (r < -2048) r = -2048;
    return int'(r);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    case (a)
      2'd0: m_hold = d;
      2'd1: m_ctrl = d[1:0];
      2'd2: m_poff = d[7:0];
      default: ;
    endcase
  endtask

  task automatic load_cf();
    cf_load = 1'b1;
    @(negedge clk);
    cf_load = 1'b0;
    m_cf = m_hold;
  endtask

  task automatic shift_ofs(input logic [31:0] w, input bit sync);
    for (int b = 31; b >= 0; b--) begin
      ofs_bit = w[b];
      ofs_sync = sync && (b == 0);
      @(negedge clk);
    end
    ofs_sync = 1'b0; ofs_bit = 1'b0;
    if (sync) m_ofs = w;
  endtask

  task automatic do_sample(input logic [9:0] ri, input logic [9:0] rq, input string req);
    logic [7:0] a;
    int iv, qv, c, s, ei, eq;
    a  = m_acc[31:24] + m_poff;
    iv = conv(ri, m_ctrl[0]);
    qv = m_ctrl[1] ? 0 : conv(rq, m_ctrl[0]);
    s  = lut(int'(a));
    c  = lut((int'(a) + 64) % 256);
    ei = rnd_sat(longint'(iv) * c + longint'(qv) * s);
    eq = rnd_sat(longint'(qv) * c - longint'(iv) * s);
    m_acc = m_acc + m_cf + m_ofs;
    i_in = ri; q_in = rq; smp_en_n = 1'b0;
    @(negedge clk);
    smp_en_n = 1'b1;
    @(negedge clk);
    chk({req, " out_vld"}, int'(out_vld), 1);
    chk({req, " i_out"}, int'($signed(i_out)), ei);
    chk({req, " q_out"}, int'($signed(q_out)), eq);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; i_in = '0; q_in = '0; smp_en_n = 1'b1; wr_en = 1'b0;
    wr_addr = '0; wr_data = '0; cf_load = 1'b0; ofs_bit = 1'b0; ofs_sync = 1'b0;
    m_acc = '0; m_cf = '0; m_hold = '0; m_ofs = '0; m_poff = '0; m_ctrl = '0;
    repeat (3) @(negedge clk);
    // R1: outputs quiet in reset and just after release
    chk("R1 out_vld in reset", int'(out_vld), 0);
    chk("R1 i_out in reset", int'(i_out), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 q_out after release", int'(q_out), 0);
    chk("R1 out_vld after release", int'(out_vld), 0);
    repeat (3) @(negedge clk);

    // Vector table: R3/R6/R7/R8 main mixing, R9 offset binary, R10 real input
    for (int v = 0; v < NV; v++) begin
      string tag;
      wr(2'd0, V_CF[v]);
      load_cf();
      wr(2'd1, {30'd0, V_CTRL[v]});
      wr(2'd2, {24'd0, V_POFF[v]});
      if (V_CTRL[v][1])      tag = $sformatf("R10 vec%0d", v);
      else if (V_CTRL[v][0]) tag = $sformatf("R9 vec%0d", v);
      else                   tag = $sformatf("R3/R6/R7/R8 vec%0d", v);
      do_sample(V_I[v], V_Q[v], tag);
    end

    // R10: two samples differing only in q_in give identical results
    wr(2'd1, 32'd2);
    wr(2'd0, 32'd0); load_cf();
    do_sample(10'd200, 10'd100, "R10 q ignored a");
    do_sample(10'd200, 10'h1F0, "R10 q ignored b");
    wr(2'd1, 32'd0);

    // R2: idle clocks leave outputs and phase untouched
    begin
      logic [11:0] hi, hq;
      wr(2'd0, 32'h0900_0000); load_cf();
      do_sample(10'd350, 10'h3A0, "R2 before idle");
      hi = i_out; hq = q_out;
      for (int k = 0; k < 5; k++) begin
        @(negedge clk);
        chk("R2 idle out_vld", int'(out_vld), 0);
        chk("R2 idle i_out hold", int'(i_out), int'(hi));
        chk("R2 idle q_out hold", int'(q_out), int'(hq));
      end
      do_sample(10'd350, 10'h3A0, "R2 after idle phase");
    end

    // R5: holding register write alone does not change the step
    wr(2'd0, 32'h4000_0000);
    do_sample(10'd300, 10'd100, "R5 no load");
    do_sample(10'd300, 10'd100, "R5 no load second");
    load_cf();
    do_sample(10'd300, 10'd100, "R5 after load");
    do_sample(10'd300, 10'd100, "R5 after load second");

    // R4: a full word without the sync strobe never takes effect
    wr(2'd0, 32'd0); load_cf();
    shift_ofs(32'h2300_0000, 1'b0);
    do_sample(10'd400, 10'd0, "R4 unsynced a");
    do_sample(10'd400, 10'd0, "R4 unsynced b");
    shift_ofs(32'h2300_0000, 1'b1);
    do_sample(10'd400, 10'd0, "R4 synced a");
    do_sample(10'd400, 10'd0, "R4 synced b");
    do_sample(10'h2A0, 10'd60, "R4 synced c");

    // R6: extreme phase offset -128 steps by half a cycle
    wr(2'd2, 32'h0000_0080);
    do_sample(10'd256, 10'd128, "R6 poff -128");

    finish_run();
  end

endmodule